// File: doc/BRIEF.md
# Timer Shared Control Registers

This block holds the control state that all channels of a multi-channel timer share: which channels are clocked, which are counting, which match events are pending and which of those may interrupt. Each of the four 32-bit registers is read at one address and modified only through two companion addresses. A write to the companion "set" address turns on the bits written as one. A write to the "clear" address turns them off. Bits written as zero keep their value, so software can change one channel without a read-modify-write sequence.

Each channel reports two match events: a full-period match and a half (duty) match. A pulse on either input sets the matching pending bit. The full bit sits at the channel's own index and the half bit sits sixteen positions higher, and the mask register uses the same layout. Each channel drives one interrupt line, which is high while any of its pending bits is unmasked. The block also decodes the per-channel register windows above the shared registers. It raises a one-hot channel select and a field code for the channel logic that lives outside this block.

Top module: `tmr_shared_regs`

## Requirements
- R1: After reset the enable register reads 0x0, the pending register reads 0x0, the stop register reads every channel bit plus bit 16 as one (0x000100FF for eight channels), and the mask register reads every implemented full and half bit as one (0x00FF00FF for eight channels).
- R2: A read returns the enable register at offset 0x10, the stop register at 0x1C, the pending register at 0x20 and the mask register at 0x30. Reads of any other offset, the set and clear offsets included, return 0.
- R3: A write to a set offset (enable 0x14, pending 0x24, mask 0x34, stop 0x2C) turns on every implemented bit written as one and leaves the other bits unchanged.
- R4: A write to a clear offset (enable 0x18, pending 0x28, mask 0x38, stop 0x3C) turns off every bit written as one and leaves the other bits unchanged.
- R5: A write to one of the four read offsets changes nothing.
- R6: A one-cycle pulse on full_hit[n] sets pending bit n, and a pulse on half_hit[n] sets pending bit n+16. Each bit is set on the next clock edge.
- R7: When a hardware hit and a clear-offset write target the same pending bit in one cycle, the bit ends up set. Other bits named by the same write are still cleared.
- R8: irq[n] is high exactly when pending bit n has mask bit n at 0, or pending bit n+16 has mask bit n+16 at 0. A mask bit of 1 blocks its source.
- R9: ch_enable[n] follows enable bit n, ch_stop[n] follows stop bit n, and wdog_stop follows stop bit 16. Bits that no channel implements always read 0.
- R10: For an address inside 0x40 + n*0x10 up to 0x4F + n*0x10, with n below the channel count, win_sel is one-hot at bit n and win_field carries address bits [3:2] (0 period, 1 duty, 2 counter, 3 control). For any other address, win_sel and win_field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address within the timer space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| full_hit | input | NCH | Full-period match pulse per channel |
| half_hit | input | NCH | Half match pulse per channel |
| ch_enable | output | NCH | Counting enable per channel |
| ch_stop | output | NCH | Clock gate per channel, 1 = stopped |
| wdog_stop | output | 1 | Watchdog clock gate, 1 = stopped |
| irq | output | NCH | Interrupt per channel |
| win_sel | output | NCH | One-hot channel window select |
| win_field | output | 2 | Register code inside the selected window |

## Verification
Two events can meet on one pending bit in the same cycle: a channel's match pulse and a software write to the pending clear offset. The bench drives both on the same falling edge, so the rising edge that follows samples them together. The write data also names a second bit that no hit touches. A read after that edge must show the hit bit still set and the other bit cleared, which shows that the set won and that the clear did take effect.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;

   localparam int unsigned MAX_CH     = 16;
   localparam int unsigned HALF_SHIFT = 16;
   localparam int unsigned WDOG_BIT   = 16;
   localparam int unsigned NREG       = 4;
   localparam int unsigned WIN_BASE   = 'h40;
   localparam int unsigned WIN_STRIDE = 'h10;

   typedef enum logic [1:0] {
      REG_EN   = 2'd0,
      REG_STOP = 2'd1,
      REG_FLAG = 2'd2,
      REG_MASK = 2'd3
   } reg_id_e;

   function automatic logic [31:0] chan_bits(input int unsigned nch);
      logic [31:0] v;
      v = '0;
      for (int unsigned i = 0; i < nch; i++) v[i] = 1'b1;
      return v;
   endfunction

   function automatic logic [31:0] impl_mask(input int unsigned rid, input int unsigned nch);
      logic [31:0] c;
      c = chan_bits(nch);
      case (rid)
         0:       return c;
         1:       return c | (32'd1 << WDOG_BIT);
         default: return c | (c << HALF_SHIFT);
      endcase
   endfunction

   function automatic logic [31:0] reset_value(input int unsigned rid, input int unsigned nch);
      if (rid == 1 || rid == 3) return impl_mask(rid, nch);
      return '0;
   endfunction

   function automatic int unsigned read_ofs(input int unsigned rid);
      case (rid)
         0:       return 'h10;
         1:       return 'h1C;
         2:       return 'h20;
         default: return 'h30;
      endcase
   endfunction

   function automatic int unsigned set_ofs(input int unsigned rid);
      case (rid)
         0:       return 'h14;
         1:       return 'h2C;
         2:       return 'h24;
         default: return 'h34;
      endcase
   endfunction

   function automatic int unsigned clr_ofs(input int unsigned rid);
      case (rid)
         0:       return 'h18;
         1:       return 'h3C;
         2:       return 'h28;
         default: return 'h38;
      endcase
   endfunction

endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
   import tmr_regs_pkg::*;
#(
   parameter int unsigned NCH    = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   output logic [NREG-1:0]   set_we,
   output logic [NREG-1:0]   clr_we,
   output logic [NREG-1:0]   rd_hit,
   output logic [NCH-1:0]    win_sel,
   output logic [1:0]        win_field
);

   localparam int unsigned BLK_W    = ADDR_W - 4;
   localparam int unsigned WIN_BLK0 = WIN_BASE / WIN_STRIDE;

   logic [BLK_W-1:0] blk;
   assign blk = addr[ADDR_W-1:4];

   for (genvar r = 0; r < NREG; r++) begin : g_reg_dec
      assign rd_hit[r] = (addr == ADDR_W'(read_ofs(r)));
      assign set_we[r] = wr && (addr == ADDR_W'(set_ofs(r)));
      assign clr_we[r] = wr && (addr == ADDR_W'(clr_ofs(r)));
   end

   for (genvar n = 0; n < NCH; n++) begin : g_win_dec
      assign win_sel[n] = (blk == BLK_W'(WIN_BLK0 + n));
   end

   assign win_field = (|win_sel) ? addr[3:2] : 2'd0;

endmodule

// File: rtl/tmr_w1sc_reg.sv
module tmr_w1sc_reg #(
   parameter int unsigned W        = 32,
   parameter logic [W-1:0] RST     = '0,
   parameter logic [W-1:0] IMPL    = '1,
   parameter bit          HW_WINS  = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);

   logic [W-1:0] set_v, clr_v, nxt;

   assign set_v = set_we ? wdata : '0;
   assign clr_v = clr_we ? wdata : '0;

   if (HW_WINS) begin : g_hw_wins
      assign nxt = (((q | set_v) & ~clr_v) | hw_set) & IMPL;
   end else begin : g_clr_wins
      assign nxt = ((q | set_v | hw_set) & ~clr_v) & IMPL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else        q <= nxt;
   end

endmodule

// File: rtl/tmr_irq_merge.sv
module tmr_irq_merge #(
   parameter int unsigned NCH = 8
) (
   input  logic [NCH-1:0] flag_full,
   input  logic [NCH-1:0] flag_half,
   input  logic [NCH-1:0] mask_full,
   input  logic [NCH-1:0] mask_half,
   output logic [NCH-1:0] irq
);

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      assign irq[n] = (flag_full[n] & ~mask_full[n]) | (flag_half[n] & ~mask_half[n]);
   end

endmodule

// File: rtl/tmr_shared_regs.sv
module tmr_shared_regs
   import tmr_regs_pkg::*;
#(
   parameter int unsigned NCH     = 8,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          HW_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NCH-1:0]    full_hit,
   input  logic [NCH-1:0]    half_hit,
   output logic [NCH-1:0]    ch_enable,
   output logic [NCH-1:0]    ch_stop,
   output logic              wdog_stop,
   output logic [NCH-1:0]    irq,
   output logic [NCH-1:0]    win_sel,
   output logic [1:0]        win_field
);

   localparam int unsigned WIN_END = WIN_BASE + NCH * WIN_STRIDE;

   if (NCH < 1 || NCH > MAX_CH) begin : g_bad_nch
      $error("tmr_shared_regs: NCH must lie in 1..16");
   end
   if (ADDR_W < 8 || WIN_END > (1 << ADDR_W)) begin : g_bad_addr
      $error("tmr_shared_regs: ADDR_W too narrow for the channel windows");
   end

   logic [NREG-1:0] set_we, clr_we, rd_hit;
   logic [31:0]     reg_q [NREG];
   logic [31:0]     flag_hw;

   tmr_addr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) dec_i (
      .addr      (bus_addr),
      .wr        (bus_wr),
      .set_we    (set_we),
      .clr_we    (clr_we),
      .rd_hit    (rd_hit),
      .win_sel   (win_sel),
      .win_field (win_field)
   );

   always_comb begin
      flag_hw = '0;
      for (int n = 0; n < int'(NCH); n++) begin
         flag_hw[n]              = full_hit[n];
         flag_hw[n + HALF_SHIFT] = half_hit[n];
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      tmr_w1sc_reg #(
         .W       (32),
         .RST     (reset_value(r, NCH)),
         .IMPL    (impl_mask(r, NCH)),
         .HW_WINS (HW_WINS)
      ) reg_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_we (set_we[r]),
         .clr_we (clr_we[r]),
         .wdata  (bus_wdata),
         .hw_set ((r == int'(REG_FLAG)) ? flag_hw : 32'd0),
         .q      (reg_q[r])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int r = 0; r < int'(NREG); r++) begin
         if (rd_hit[r]) bus_rdata = bus_rdata | reg_q[r];
      end
   end

   assign ch_enable = reg_q[REG_EN][NCH-1:0];
   assign ch_stop   = reg_q[REG_STOP][NCH-1:0];
   assign wdog_stop = reg_q[REG_STOP][WDOG_BIT];

   tmr_irq_merge #(.NCH(NCH)) irq_i (
      .flag_full (reg_q[REG_FLAG][NCH-1:0]),
      .flag_half (reg_q[REG_FLAG][HALF_SHIFT +: NCH]),
      .mask_full (reg_q[REG_MASK][NCH-1:0]),
      .mask_half (reg_q[REG_MASK][HALF_SHIFT +: NCH]),
      .irq       (irq)
   );

endmodule

// File: rtl/tmr_shared_regs_chk.sv
module tmr_shared_regs_chk
   import tmr_regs_pkg::*;
#(
   parameter int unsigned NCH     = 8,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          HW_WINS = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [NCH-1:0]    full_hit,
   input logic [NCH-1:0]    half_hit,
   input logic [NCH-1:0]    irq,
   input logic [NCH-1:0]    win_sel,
   input logic [31:0]       en_q,
   input logic [31:0]       flag_q,
   input logic [31:0]       mask_q
);

   // R1
   mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_q == impl_mask(3, NCH)) && (flag_q == 32'd0));

   // R4
   mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(clr_ofs(3))) |=> ((mask_q & $past(bus_wdata)) == 32'd0));

   // R5
   en_base_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(read_ofs(0))) |=> $stable(en_q));

   // R10
   win_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win_sel));

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      if (HW_WINS) begin : g_prio
         // R6 R7
         full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            full_hit[n] |=> flag_q[n]);
         // R6 R7
         half_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            half_hit[n] |=> flag_q[n + HALF_SHIFT]);
      end
      // R8
      irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[n] && mask_q[n + HALF_SHIFT]) |-> !irq[n]);
      // R8
      irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!flag_q[n] && !flag_q[n + HALF_SHIFT]) |-> !irq[n]);
   end

endmodule

bind tmr_shared_regs tmr_shared_regs_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .HW_WINS(HW_WINS)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .full_hit  (full_hit),
   .half_hit  (half_hit),
   .irq       (irq),
   .win_sel   (win_sel),
   .en_q      (reg_q[0]),
   .flag_q    (reg_q[2]),
   .mask_q    (reg_q[3])
);

// File: tb/tmr_shared_regs_tb.sv
module tmr_shared_regs_tb_top;

   localparam int unsigned CLK_P  = 10;
   localparam int unsigned NCH    = 8;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned NVEC   = 12;

   typedef struct packed {
      logic [7:0]  waddr;
      logic [31:0] wdata;
      logic [7:0]  raddr;
      logic [31:0] exp;
      logic [15:0] tag;
   } vec_t;

   localparam vec_t VEC [NVEC] = '{
      '{8'h14, 32'h0000_0005, 8'h10, 32'h0000_0005, "R3"},
      '{8'h14, 32'h0000_0102, 8'h10, 32'h0000_0007, "R9"},
      '{8'h18, 32'h0000_0004, 8'h10, 32'h0000_0003, "R4"},
      '{8'h3C, 32'h0001_0003, 8'h1C, 32'h0000_00FC, "R4"},
      '{8'h2C, 32'h0001_0000, 8'h1C, 32'h0001_00FC, "R3"},
      '{8'h38, 32'h0001_0001, 8'h30, 32'h00FE_00FE, "R4"},
      '{8'h34, 32'h0000_0001, 8'h30, 32'h00FE_00FF, "R3"},
      '{8'h24, 32'h0003_0000, 8'h20, 32'h0003_0000, "R3"},
      '{8'h28, 32'h0001_0000, 8'h20, 32'h0002_0000, "R4"},
      '{8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0003, "R5"},
      '{8'h20, 32'h0000_FFFF, 8'h20, 32'h0002_0000, "R5"},
      '{8'h04, 32'hFFFF_FFFF, 8'h14, 32'h0000_0000, "R2"}
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    full_hit = '0;
   logic [NCH-1:0]    half_hit = '0;
   logic [NCH-1:0]    ch_enable, ch_stop, irq, win_sel;
   logic              wdog_stop;
   logic [1:0]        win_field;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   tmr_shared_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .full_hit  (full_hit),
      .half_hit  (half_hit),
      .ch_enable (ch_enable),
      .ch_stop   (ch_stop),
      .wdog_stop (wdog_stop),
      .irq       (irq),
      .win_sel   (win_sel),
      .win_field (win_field)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
   endtask

   task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(tag, $sformatf("read 0x%02h", a), bus_rdata, exp);
   endtask

   task automatic hit(input logic [NCH-1:0] f, input logic [NCH-1:0] h);
      @(negedge clk);
      full_hit = f;
      half_hit = h;
      @(negedge clk);
      full_hit = '0;
      half_hit = '0;
   endtask

   task automatic win(input logic [7:0] a, input logic [NCH-1:0] es, input logic [1:0] ef);
      bus_addr = a;
      #1;
      chk("R10", $sformatf("win_sel at 0x%02h", a), 32'(win_sel), 32'(es));
      chk("R10", $sformatf("win_field at 0x%02h", a), 32'(win_field), 32'(ef));
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd("R1", 8'h10, 32'h0000_0000);
      rd("R1", 8'h1C, 32'h0001_00FF);
      rd("R1", 8'h20, 32'h0000_0000);
      rd("R1", 8'h30, 32'h00FF_00FF);
      chk("R1", "irq", 32'(irq), 32'h0);
      chk("R1", "ch_stop", 32'(ch_stop), 32'hFF);
      chk("R1", "wdog_stop", 32'(wdog_stop), 32'h1);
      chk("R1", "ch_enable", 32'(ch_enable), 32'h0);
      // R2 alias offsets read zero
      rd("R2", 8'h34, 32'h0);
      rd("R2", 8'h3C, 32'h0);

      for (int i = 0; i < int'(NVEC); i++) begin
         wr(VEC[i].waddr, VEC[i].wdata);
         rd($sformatf("%s", VEC[i].tag), VEC[i].raddr, VEC[i].exp);
      end

      // R9 outputs follow registers
      chk("R9", "ch_enable", 32'(ch_enable), 32'h03);
      chk("R9", "ch_stop", 32'(ch_stop), 32'hFC);
      chk("R9", "wdog_stop", 32'(wdog_stop), 32'h1);

      // R8 masked half pending, then unmask it, then clear it
      chk("R8", "irq masked", 32'(irq), 32'h0);
      wr(8'h38, 32'h0002_0000);
      #1;
      chk("R8", "irq half ch1", 32'(irq), 32'h02);
      wr(8'h28, 32'h0002_0000);
      #1;
      chk("R8", "irq after clear", 32'(irq), 32'h0);

      // R6 hardware hits
      hit(8'h04, 8'h00);
      rd("R6", 8'h20, 32'h0000_0004);
      hit(8'h00, 8'h08);
      rd("R6", 8'h20, 32'h0008_0004);
      chk("R8", "irq with masked hits", 32'(irq), 32'h0);

      // R7 hit and clear in the same cycle
      @(negedge clk);
      bus_addr  = 8'h28;
      bus_wdata = 32'h0008_0004;
      bus_wr    = 1'b1;
      full_hit  = 8'h04;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_wdata = '0;
      full_hit  = '0;
      rd("R7", 8'h20, 32'h0000_0004);

      // R8 unmask full of ch2
      wr(8'h38, 32'h0000_0004);
      #1;
      chk("R8", "irq full ch2", 32'(irq), 32'h04);

      // R10 window decode
      win(8'h40, 8'h01, 2'd0);
      win(8'h58, 8'h02, 2'd2);
      win(8'h74, 8'h08, 2'd1);
      win(8'hBC, 8'h80, 2'd3);
      win(8'hC0, 8'h00, 2'd0);
      win(8'h20, 8'h00, 2'd0);

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

endmodule